// File: doc/BRIEF.md
# Supply Supervisor with Reset Hold-Off and Bus-Kicked Watchdog

This block supervises a microprocessor system. Comparator results come in as logic levels: one flag says the main supply is good and one says the auxiliary supply is good. Reset is asserted while the main supply is bad or the manual reset line is held low. Once both conditions clear, reset stays asserted for a hold-off delay, and that delay restarts if either condition drops again before it ends. A 2-bit select picks one of four hold-off lengths, each set by a parameter in clock cycles. Reset is driven on two outputs of opposite polarity.

A watchdog counts clock cycles after reset releases. There is no dedicated kick pin. The watchdog restarts only when a particular pattern appears on the two-wire serial bus. First the data line must fall in the same sample as the clock line falls, which arms the watchdog. After that, a stop condition must follow, meaning the data line rises while the clock line is high. If no restart arrives within the timeout, the active-low watchdog output asserts. The block also passes the auxiliary supply status straight to a fail flag with no hold-off, and it produces a write-enable for an attached memory. That write-enable is blocked by the write-protect input and during reset.

All asynchronous inputs, including both bus lines, pass through one shared two-stage synchronizer before any decision is made.

Top module: `supv_ctrl`

## Requirements
- R1: After `rst_n` releases, and at any time `vmain_ok` is low, `rst_o` is 1. A low on `vmain_ok` shows as `rst_o`=1 three clock edges after it is applied.
- R2: When `vmain_ok` and `mrst_n` are both high, `rst_o` falls exactly HOLD+2 edges after the later of the two rose. HOLD is the selected hold-off length. A drop of either input during the hold-off restarts the full delay.
- R3: `hold_sel` picks the hold-off length: 0 selects HOLD_0, 1 selects HOLD_1, 2 selects HOLD_2 and 3 selects HOLD_3.
- R4: While `mrst_n` is low, `rst_o` is 1. After `mrst_n` returns high, reset lasts one full hold-off period (release at HOLD+2 edges).
- R5: `rst_no` is always the complement of `rst_o`.
- R6: When the bus is armed and a stop condition follows, the watchdog restarts. Arming means `sda` and `scl` fall in the same synchronized sample. A stop condition means `sda` rises while `scl` is high. After a restart, `wdog_no` is 1 three edges after the `sda` rise, and the timeout count begins again.
- R7: A stop condition that has no arming pattern before it has no effect on the watchdog. An arming pattern that no stop follows also has no effect.
- R8: When no restart arrives, `wdog_no` goes to 0 exactly WDT_CYC edges after reset released or after the last restart took effect.
- R9: While reset is asserted, the watchdog counter is held clear and `wdog_no` is 1 from the edge after `rst_o` rises.
- R10: `aux_fail_no` follows `vaux_ok` two edges later, with no hold-off.
- R11: `wr_en` is 1 only when `wprot` is low and reset is not asserted. A change on `wprot` reaches `wr_en` two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous register reset, active low |
| vmain_ok | input | 1 | Main supply above trip level |
| vaux_ok | input | 1 | Auxiliary supply above trip level |
| mrst_n | input | 1 | Manual reset request, active low |
| wprot | input | 1 | Write-protect, high blocks all writes |
| scl | input | 1 | Serial bus clock line |
| sda | input | 1 | Serial bus data line |
| hold_sel | input | 2 | Hold-off length select |
| rst_o | output | 1 | System reset, active high |
| rst_no | output | 1 | System reset, active low |
| wdog_no | output | 1 | Watchdog expired, active low |
| aux_fail_no | output | 1 | Auxiliary supply failed, active low |
| wr_en | output | 1 | Write permission for memory and registers |

## Verification
Every input reaches the design through a two-stage synchronizer. Pure passthroughs (`aux_fail_no`, and the write-protect part of `wr_en`) are due two edges after the bench drives them. Registered reactions are due on the third edge: a reset rising on a supply drop, or the watchdog clearing after a stop condition. The reset release is due at HOLD+2 edges, and the watchdog expiry is due WDT_CYC edges after the release or restart took effect. The bench drives inputs just after a falling edge and records each expected value with its due falling-edge index. A monitor compares the output at exactly that index, and also one edge earlier where an edge must not come too soon.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // bit positions inside the shared synchronizer vector
    localparam int SY_SCL   = 0;
    localparam int SY_SDA   = 1;
    localparam int SY_VMAIN = 2;
    localparam int SY_MRST  = 3;
    localparam int SY_VAUX  = 4;
    localparam int SY_WPROT = 5;
    localparam int SY_W     = 6;

    // idle values: bus lines high, supply bad, no manual request, protected
    localparam logic [SY_W-1:0] SY_IDLE = 6'b101011;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int              W      = 1,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] pipe_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[0] <= RST_V;
                else        pipe_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[s] <= RST_V;
                else        pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/supv_holdoff.sv
module supv_holdoff #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_bad,
    input  logic [CW-1:0] hold_lim,
    output logic          rst_act
);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } ho_t;

    ho_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_bad) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.act) begin
            if (st_q.cnt == hold_lim - CW'(1)) begin
                st_d.act = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{act: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign rst_act = st_q.act;

endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
    parameter int WDT_CYC = 200,
    localparam int WW = $clog2(WDT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic scl_s,
    input  logic sda_s,
    output logic kick,
    output logic expired
);

    typedef struct packed {
        logic          scl_p;
        logic          sda_p;
        logic          armed;
        logic          wdo;
        logic [WW-1:0] cnt;
    } wd_t;

    wd_t  st_d, st_q;
    logic scl_fall, sda_fall, sda_rise, stop_c;

    always_comb begin
        scl_fall = st_q.scl_p & ~scl_s;
        sda_fall = st_q.sda_p & ~sda_s;
        sda_rise = ~st_q.sda_p & sda_s;
        stop_c   = sda_rise & scl_s & st_q.scl_p;
        kick     = st_q.armed & stop_c;

        st_d       = st_q;
        st_d.scl_p = scl_s;
        st_d.sda_p = sda_s;
        if (scl_fall && sda_fall) st_d.armed = 1'b1;
        else if (stop_c)          st_d.armed = 1'b0;

        if (clr || kick) begin
            st_d.cnt = '0;
            st_d.wdo = 1'b0;
        end else if (st_q.cnt == WW'(WDT_CYC - 1)) begin
            st_d.wdo = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + WW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{scl_p: 1'b1, sda_p: 1'b1, armed: 1'b0, wdo: 1'b0, cnt: '0};
        else        st_q <= st_d;
    end

    assign expired = st_q.wdo;

endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
    import supv_pkg::*;
#(
    parameter int HOLD_0  = 10,
    parameter int HOLD_1  = 20,
    parameter int HOLD_2  = 40,
    parameter int HOLD_3  = 80,
    parameter int WDT_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vmain_ok,
    input  logic       vaux_ok,
    input  logic       mrst_n,
    input  logic       wprot,
    input  logic       scl,
    input  logic       sda,
    input  logic [1:0] hold_sel,
    output logic       rst_o,
    output logic       rst_no,
    output logic       wdog_no,
    output logic       aux_fail_no,
    output logic       wr_en
);

    localparam int CW = $clog2(max4(HOLD_0, HOLD_1, HOLD_2, HOLD_3) + 1);

    logic [SY_W-1:0] raw, syn;
    logic            vmain_s, mrst_s, vaux_s, wprot_s, scl_s, sda_s;
    logic [CW-1:0]   hold_lim;
    logic            rst_q, kick, wd_exp;

    always_comb begin
        raw           = '0;
        raw[SY_SCL]   = scl;
        raw[SY_SDA]   = sda;
        raw[SY_VMAIN] = vmain_ok;
        raw[SY_MRST]  = mrst_n;
        raw[SY_VAUX]  = vaux_ok;
        raw[SY_WPROT] = wprot;
    end

    supv_sync #(.W(SY_W), .STAGES(2), .RST_V(SY_IDLE)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (syn)
    );

    assign scl_s   = syn[SY_SCL];
    assign sda_s   = syn[SY_SDA];
    assign vmain_s = syn[SY_VMAIN];
    assign mrst_s  = syn[SY_MRST];
    assign vaux_s  = syn[SY_VAUX];
    assign wprot_s = syn[SY_WPROT];

    always_comb begin
        unique case (hold_sel)
            2'd0:    hold_lim = CW'(HOLD_0);
            2'd1:    hold_lim = CW'(HOLD_1);
            2'd2:    hold_lim = CW'(HOLD_2);
            default: hold_lim = CW'(HOLD_3);
        endcase
    end

    supv_holdoff #(.CW(CW)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_bad(~vmain_s | ~mrst_s),
        .hold_lim(hold_lim),
        .rst_act (rst_q)
    );

    supv_wdog #(.WDT_CYC(WDT_CYC)) wd_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rst_q),
        .scl_s  (scl_s),
        .sda_s  (sda_s),
        .kick   (kick),
        .expired(wd_exp)
    );

    assign rst_o       = rst_q;
    assign rst_no      = ~rst_q;
    assign wdog_no     = ~wd_exp;
    assign aux_fail_no = vaux_s;
    assign wr_en       = ~wprot_s & ~rst_q;

endmodule

module supv_chk (
    input logic clk,
    input logic rst_n,
    input logic rst_o,
    input logic wdog_no,
    input logic vmain_s,
    input logic mrst_s,
    input logic kick
);

    // R1
    supply_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vmain_s |=> rst_o);

    // R4
    manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mrst_s |=> rst_o);

    // R2
    release_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_o) |-> ($past(vmain_s) && $past(mrst_s)));

    // R9
    wd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> wdog_no);

    // R6
    kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> wdog_no);

    // R8
    wd_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdog_no) |-> $past(!rst_o));

endmodule

bind supv_ctrl supv_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_o  (rst_o),
    .wdog_no(wdog_no),
    .vmain_s(vmain_s),
    .mrst_s (mrst_s),
    .kick   (kick)
);

// File: tb/supv_ctrl_tb_top.sv
module supv_ctrl_tb_top;

    localparam int H0 = 10, H1 = 20, H2 = 40, H3 = 80, WDT = 200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic vmain_ok = 1'b0, vaux_ok = 1'b0, mrst_n = 1'b1, wprot = 1'b0;
    logic scl = 1'b1, sda = 1'b1;
    logic [1:0] hold_sel = 2'd0;
    logic rst_o, rst_no, wdog_no, aux_fail_no, wr_en;

    always #4 clk = ~clk;

    supv_ctrl #(.HOLD_0(H0), .HOLD_1(H1), .HOLD_2(H2), .HOLD_3(H3), .WDT_CYC(WDT)) dut_i (
        .clk(clk), .rst_n(rst_n), .vmain_ok(vmain_ok), .vaux_ok(vaux_ok),
        .mrst_n(mrst_n), .wprot(wprot), .scl(scl), .sda(sda), .hold_sel(hold_sel),
        .rst_o(rst_o), .rst_no(rst_no), .wdog_no(wdog_no),
        .aux_fail_no(aux_fail_no), .wr_en(wr_en)
    );

    typedef enum int {S_RST, S_RSTN, S_WDG, S_AUX, S_WEN} sig_e;
    typedef struct {
        int    due;
        sig_e  sig;
        logic  val;
        string tag;
    } item_t;

    item_t sb_q[$];
    int cyc = 0, total = 0, bad = 0;

    function automatic logic peek(sig_e s);
        case (s)
            S_RST:   return rst_o;
            S_RSTN:  return rst_no;
            S_WDG:   return wdog_no;
            S_AUX:   return aux_fail_no;
            default: return wr_en;
        endcase
    endfunction

    task automatic judge(sig_e s, logic v, string tag);
        logic a;
        a = peek(s);
        total++;
        if (a !== v) begin
            bad++;
            $display("FAIL %s sig=%s actual=%b expected=%b t=%0t", tag, s.name(), a, v, $time);
        end
    endtask

    // monitor: compare every queued item on its due falling edge
    always @(negedge clk) begin
        cyc++;
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].due == cyc) begin
                judge(sb_q[i].sig, sb_q[i].val, sb_q[i].tag);
                sb_q.delete(i);
            end
        end
    end

    task automatic expect_at(int d, sig_e s, logic v, string tag);
        item_t it;
        it.due = cyc + d; it.sig = s; it.val = v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    // release check for a rise of the hold condition just driven
    task automatic expect_release(int hold, string tag);
        expect_at(hold + 1, S_RST, 1'b1, tag);
        expect_at(hold + 2, S_RST, 1'b0, tag);
        expect_at(hold + 2, S_RSTN, 1'b1, "R5");
    endtask

    // arming pattern followed by a stop; ends on the stop drive
    task automatic kick_bus();
        scl = 1'b0; sda = 1'b0;
        step(3);
        scl = 1'b1;
        step(3);
        sda = 1'b1;
    endtask

    initial begin
        step(3);
        judge(S_RST, 1'b1, "R1 reset state");
        judge(S_RSTN, 1'b0, "R5 reset state");
        judge(S_WDG, 1'b1, "R9 reset state");
        judge(S_AUX, 1'b0, "R10 reset state");
        judge(S_WEN, 1'b0, "R11 reset state");
        rst_n = 1'b1;
        step(6);
        judge(S_RST, 1'b1, "R1 supply low");
        judge(S_WEN, 1'b0, "R11 blocked in reset");

        // R2 release, then R8 expiry from release
        vmain_ok = 1'b1;
        expect_release(H0, "R2");
        expect_at(H0 + 2, S_WEN, 1'b1, "R11");
        expect_at(H0 + 1 + WDT, S_WDG, 1'b1, "R8 early");
        expect_at(H0 + 2 + WDT, S_WDG, 1'b0, "R8");
        step(H0 + WDT + 6);

        // R6 restart clears, R8 expiry after restart
        kick_bus();
        expect_at(3, S_WDG, 1'b1, "R6");
        expect_at(WDT + 2, S_WDG, 1'b1, "R8 early");
        expect_at(WDT + 3, S_WDG, 1'b0, "R8 after restart");
        step(WDT + 6);

        // R7 stop with no arming: start then stop
        sda = 1'b0; step(3);
        sda = 1'b1; step(6);
        judge(S_WDG, 1'b0, "R7 stop without arming");
        // R7 arming with no stop
        scl = 1'b0; sda = 1'b0; step(3);
        scl = 1'b1; step(10);
        judge(S_WDG, 1'b0, "R7 arming without stop");
        sda = 1'b1;
        expect_at(3, S_WDG, 1'b1, "R6 late stop");
        step(6);

        // R6 periodic restarts keep the watchdog quiet
        for (int k = 0; k < 4; k++) begin
            kick_bus();
            expect_at(WDT / 2, S_WDG, 1'b1, "R6 periodic");
            step(WDT / 2);
        end
        step(4);

        // R10 auxiliary flag
        vaux_ok = 1'b1;
        expect_at(1, S_AUX, 1'b0, "R10 early");
        expect_at(2, S_AUX, 1'b1, "R10");
        step(4);
        vaux_ok = 1'b0;
        expect_at(2, S_AUX, 1'b0, "R10");
        step(4);

        // R11 write protect
        wprot = 1'b1;
        expect_at(1, S_WEN, 1'b1, "R11 early");
        expect_at(2, S_WEN, 1'b0, "R11 protect");
        step(4);
        wprot = 1'b0;
        expect_at(2, S_WEN, 1'b1, "R11 unprotect");
        step(WDT + 8);
        judge(S_WDG, 1'b0, "R8 expired again");

        // R1 supply drop, R9 watchdog cleared in reset
        vmain_ok = 1'b0;
        expect_at(3, S_RST, 1'b1, "R1 drop");
        expect_at(3, S_WEN, 1'b0, "R11 reset blocks");
        expect_at(4, S_WDG, 1'b1, "R9");
        step(8);

        // R2 dropout inside the hold-off restarts the delay
        vmain_ok = 1'b1; step(H0 / 2);
        vmain_ok = 1'b0; step(1);
        vmain_ok = 1'b1;
        expect_release(H0, "R2 restart");
        step(H0 + 6);

        // R3 each select value
        for (int s = 1; s < 4; s++) begin
            int h;
            h = (s == 1) ? H1 : (s == 2) ? H2 : H3;
            vmain_ok = 1'b0; step(6);
            hold_sel = 2'(s);
            vmain_ok = 1'b1;
            expect_release(h, "R3");
            step(h + 6);
        end

        // R4 manual reset
        mrst_n = 1'b0;
        expect_at(3, S_RST, 1'b1, "R4 hold");
        expect_at(30, S_RST, 1'b1, "R4 hold");
        step(32);
        mrst_n = 1'b1;
        expect_release(H3, "R4 release");
        step(H3 + 6);

        if (sb_q.size() != 0) begin
            total++; bad++;
            $display("FAIL queue not drained actual=%0d expected=0", sb_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule